// File: doc/BRIEF.md
# Pin Configuration Write Guard

This unit sits in front of a bank of four pin-configuration registers (alternate function enable, pull-up enable, control select, digital enable) on a simple memory-mapped bus. The bus has an address, a write strobe with write data, and a read strobe with read data. Each configuration register has one bit per pin. A commit mask decides which bits a bus write may change. Bits whose mask bit is 0 keep their stored value.

One pin is protected. Its mask bit resets to 0 and is the only mask bit that can be written. Every other mask bit is tied to 1. The mask itself can be written only after a 32-bit key has been written to a lock register. Any write to the mask closes the lock again. Clearing the protected pin's special function therefore takes three deliberate writes: the key, then the mask bit, then the configuration register.

The current configuration register values are driven onto output ports for the pad logic. The reset input is asynchronous and active low. It is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `pin_cfg_guard`

## Requirements
- R1: After reset the lock reads as locked and the mask reads 0x7F (guard bit 7 clear, all other bits set). The configuration registers reset as follows: alternate function 0x80, pull-up 0x00, control select 0x00, digital enable 0x80.
- R2: A write of exactly 0x4C4F434B to the lock register (offset 0x520) opens the lock. A write of any other value to the lock register closes it.
- R3: A read of the lock register returns 0x00000001 while locked and 0x00000000 while open.
- R4: While the lock is closed, writes to the mask register (offset 0x524) leave the mask unchanged.
- R5: While the lock is open, a write to the mask register stores write-data bit 7 into the guard mask bit. The same write closes the lock.
- R6: Mask bits 0 to 6 always read as 1, even after a write of 0 to them.
- R7: A write to a configuration register takes write-data bits [7:0] only where the mask bit is 1. Bits whose mask bit is 0 keep their previous value. Write-data bits above bit 7 are ignored.
- R8: Writes to configuration registers or to unmapped addresses do not change the lock state.
- R9: The alternate-function bit of pin 7 can be cleared only by this sequence: write the key, set mask bit 7, then write the alternate-function register. The same configuration write without the first two steps leaves the bit at 1.
- R10: Reads return the configuration registers at 0x420 (alternate function), 0x510 (pull-up), 0x52C (control select) and 0x51C (digital enable), zero-extended. Unmapped addresses read 0, and the read data is 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| pin_altfn | output | 8 | Alternate-function enable per pin |
| pin_pullup | output | 8 | Pull-up enable per pin |
| pin_ctlsel | output | 8 | Control select per pin |
| pin_digen | output | 8 | Digital enable per pin |

## Verification
Each configuration register is swept over all 256 data values with junk in the upper bits. A design that ignored the mask, or that leaked the upper data bits, would corrupt pin 7 or the stored value.

The lock is tested with the key and with all 32 single-bit corruptions of it. A comparator that checks too few bits would unlock on a near-miss key.

Two orderings are tested. A write to the mask while the lock is closed must be dropped. A write while the lock is open must be kept and must also close the lock. A design that evaluated the lock after the relock would drop the write. A design that forgot the relock would leave the mask writable.

Writes of all zeros to the hardwired mask bits, and interleaved writes to configuration registers and unmapped addresses, show whether those bits are truly fixed and whether unrelated traffic disturbs the lock.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NUM_CFG = 4;
  // index of each configuration register in the bank
  localparam int unsigned IDX_ALTFN  = 0;
  localparam int unsigned IDX_PULLUP = 1;
  localparam int unsigned IDX_CTLSEL = 2;
  localparam int unsigned IDX_DIGEN  = 3;

  typedef enum logic {
    ST_LOCKED = 1'b0,
    ST_OPEN   = 1'b1
  } lock_state_e;
endpackage

// File: rtl/pcg_rst_sync.sv
module pcg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/pcg_lock_ctrl.sv
module pcg_lock_ctrl
  import pcg_pkg::*;
#(
  parameter logic [WORD_W-1:0] KEY = 32'h4C4F434B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic              wr_mask,
  input  logic [WORD_W-1:0] wdata,
  output logic              locked
);
  lock_state_e state_q;
  lock_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (wr_lock) begin
      state_d = (wdata == KEY) ? ST_OPEN : ST_LOCKED;
    end else if (wr_mask) begin
      state_d = ST_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOCKED;
    end else begin
      state_q <= state_d;
    end
  end

  assign locked = (state_q == ST_LOCKED);

  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && (wdata == KEY)) |=> !locked);
  assert_bad_key_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && (wdata != KEY)) |=> locked);
  assert_mask_write_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> locked);
  assert_other_traffic_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lock && !wr_mask) |=> $stable(locked));
endmodule

// File: rtl/pcg_commit_mask.sv
module pcg_commit_mask #(
  parameter int unsigned NPINS     = 8,
  parameter int unsigned GUARD_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mask,
  input  logic             locked,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] mask
);
  logic guard_q;
  logic guard_d;
  logic guard_en;

  assign guard_en = wr_mask && !locked;

  always_comb begin
    guard_d = guard_q;
    if (guard_en) begin
      guard_d = wdata[GUARD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q <= 1'b0;
    end else begin
      guard_q <= guard_d;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    if (i == GUARD_BIT) begin : g_guard
      assign mask[i] = guard_q;
    end else begin : g_fixed
      assign mask[i] = 1'b1;
    end
  end

  assert_locked_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && locked) |=> $stable(mask));
  assert_open_stores_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !locked) |=> (mask[GUARD_BIT] == $past(wdata[GUARD_BIT])));
endmodule

// File: rtl/pcg_masked_reg.sv
module pcg_masked_reg #(
  parameter int unsigned     W   = 8,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_r;
    if (wr) begin
      q_d = (q_r & ~mask) | (wdata & mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RST;
    end else begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

  assert_masked_bits_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/pin_cfg_guard.sv
module pin_cfg_guard
  import pcg_pkg::*;
#(
  parameter int unsigned NPINS     = 8,
  parameter int unsigned GUARD_BIT = 7,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [WORD_W-1:0] KEY = 32'h4C4F434B,
  parameter logic [ADDR_W-1:0] OFS_LOCK = 12'h520,
  parameter logic [ADDR_W-1:0] OFS_MASK = 12'h524,
  // packed per register index: {digen, ctlsel, pullup, altfn}
  parameter logic [NUM_CFG*ADDR_W-1:0] CFG_OFS = {12'h51C, 12'h52C, 12'h510, 12'h420},
  parameter logic [NUM_CFG*NPINS-1:0]  CFG_RST = {8'h80, 8'h00, 8'h00, 8'h80}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NPINS-1:0]  pin_altfn,
  output logic [NPINS-1:0]  pin_pullup,
  output logic [NPINS-1:0]  pin_ctlsel,
  output logic [NPINS-1:0]  pin_digen
);
  logic               rst_n_s;
  logic               hit_lock;
  logic               hit_mask;
  logic [NUM_CFG-1:0] hit_cfg;
  logic               locked;
  logic [NPINS-1:0]   mask;
  logic [NPINS-1:0]   cfg_q [NUM_CFG];

  pcg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    hit_lock = (bus_addr == OFS_LOCK);
    hit_mask = (bus_addr == OFS_MASK);
    for (int k = 0; k < NUM_CFG; k++) begin
      hit_cfg[k] = (bus_addr == CFG_OFS[k*ADDR_W +: ADDR_W]);
    end
  end

  pcg_lock_ctrl #(.KEY(KEY)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_lock (bus_wr && hit_lock),
    .wr_mask (bus_wr && hit_mask),
    .wdata   (bus_wdata),
    .locked  (locked)
  );

  pcg_commit_mask #(.NPINS(NPINS), .GUARD_BIT(GUARD_BIT)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_mask (bus_wr && hit_mask),
    .locked  (locked),
    .wdata   (bus_wdata[NPINS-1:0]),
    .mask    (mask)
  );

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    pcg_masked_reg #(
      .W   (NPINS),
      .RST (CFG_RST[k*NPINS +: NPINS])
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n_s),
      .wr    (bus_wr && hit_cfg[k]),
      .wdata (bus_wdata[NPINS-1:0]),
      .mask  (mask),
      .q     (cfg_q[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_lock) begin
        bus_rdata[0] = locked;
      end else if (hit_mask) begin
        bus_rdata[NPINS-1:0] = mask;
      end else begin
        for (int k = 0; k < NUM_CFG; k++) begin
          if (hit_cfg[k]) begin
            bus_rdata[NPINS-1:0] = cfg_q[k];
          end
        end
      end
    end
  end

  assign pin_altfn  = cfg_q[IDX_ALTFN];
  assign pin_pullup = cfg_q[IDX_PULLUP];
  assign pin_ctlsel = cfg_q[IDX_CTLSEL];
  assign pin_digen  = cfg_q[IDX_DIGEN];

  assert_lock_read_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rd && hit_lock) |-> (bus_rdata[WORD_W-1:1] == '0));
  assert_guard_fn_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!mask[GUARD_BIT]) |=> (pin_altfn[GUARD_BIT] == $past(pin_altfn[GUARD_BIT])));
  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/tb_pin_cfg_guard.sv
module tb_pin_cfg_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h4C4F434B;
  localparam logic [11:0] A_LOCK = 12'h520;
  localparam logic [11:0] A_MASK = 12'h524;
  localparam logic [11:0] A_CFG [4] = '{12'h420, 12'h510, 12'h52C, 12'h51C};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_altfn, pin_pullup, pin_ctlsel, pin_digen;

  int n_checks = 0;
  int n_fail   = 0;

  // requirement-level model
  logic       m_locked;
  logic       m_guard;
  logic [7:0] m_cfg [4];

  pin_cfg_guard dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_altfn(pin_altfn), .pin_pullup(pin_pullup),
    .pin_ctlsel(pin_ctlsel), .pin_digen(pin_digen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pin_out(input int k);
    case (k)
      0: return pin_altfn;
      1: return pin_pullup;
      2: return pin_ctlsel;
      default: return pin_digen;
    endcase
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    logic [7:0] msk;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    msk = {m_guard, 7'h7F};
    if (a == A_LOCK) begin
      m_locked = (d != KEY);
    end else if (a == A_MASK) begin
      if (!m_locked) m_guard = d[7];
      m_locked = 1'b1;
    end else begin
      for (int k = 0; k < 4; k++)
        if (a == A_CFG[k]) m_cfg[k] = (m_cfg[k] & ~msk) | (d[7:0] & msk);
    end
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic check_lock(input string req);
    logic [31:0] r;
    bus_read(A_LOCK, r);
    check(req, r, {31'b0, m_locked});
  endtask

  task automatic check_mask(input string req);
    logic [31:0] r;
    bus_read(A_MASK, r);
    check(req, r, {24'b0, m_guard, 7'h7F});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    m_locked = 1'b1; m_guard = 1'b0;
    m_cfg[0] = 8'h80; m_cfg[1] = 8'h00; m_cfg[2] = 8'h00; m_cfg[3] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_lock("R1 lock");
    check_mask("R1 mask");
    for (int k = 0; k < 4; k++) check("R1 cfg", {24'b0, pin_out(k)}, {24'b0, m_cfg[k]});

    // R7 sweep of every configuration register with the reset mask
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 256; v++) begin
        bus_write(A_CFG[k], {24'hA5C3E1 ^ 24'(v * 7), 8'(v)});
        check("R7 masked write", {24'b0, pin_out(k)}, {24'b0, m_cfg[k]});
      end
      bus_read(A_CFG[k], r);
      check("R10 cfg read", r, {24'b0, m_cfg[k]});
    end
    check_lock("R8 lock after cfg traffic");

    // R9 without key: pin 7 special function cannot be cleared
    bus_write(A_CFG[0], 32'h0);
    check("R9 no key", {31'b0, pin_altfn[7]}, 32'h1);

    // R4 mask write while locked is dropped
    bus_write(A_MASK, 32'hFFFF_FFFF);
    check_mask("R4 locked mask write");
    check_lock("R4 still locked");

    // R2 key and every single-bit corruption of it
    for (int b = 0; b < 32; b++) begin
      bus_write(A_LOCK, KEY);
      check_lock("R2 key opens");
      check("R3 open reads 0", {31'b0, m_locked}, 32'h0);
      bus_write(A_LOCK, KEY ^ (32'h1 << b));
      check_lock("R2 wrong key closes");
    end

    // R8 unrelated traffic while open keeps the lock open
    bus_write(A_LOCK, KEY);
    bus_write(A_CFG[1], 32'h5A);
    bus_write(12'h100, 32'hFFFF_FFFF);
    check_lock("R8 open held");

    // R5 / R9 full sequence
    bus_write(A_MASK, 32'h0000_0080);
    check_mask("R5 mask stored");
    check_lock("R5 relocked");
    bus_write(A_CFG[0], 32'h0000_0000);
    check("R9 full sequence clears pin 7", {24'b0, pin_altfn}, {24'b0, m_cfg[0]});
    check("R9 pin 7 cleared", {31'b0, pin_altfn[7]}, 32'h0);

    // R6 hardwired bits survive a write of zero; guard back to 0
    bus_write(A_LOCK, KEY);
    bus_write(A_MASK, 32'h0);
    check_mask("R6 fixed bits");
    bus_write(A_CFG[0], 32'hFF);
    check("R6 pin 7 protected again", {24'b0, pin_altfn}, {24'b0, m_cfg[0]});

    // R10 unmapped read and idle read
    bus_read(12'h100, r);
    check("R10 unmapped read", r, 32'h0);
    @(negedge clk);
    bus_addr = A_CFG[3];
    #1 check("R10 idle read", bus_rdata, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule